// File: doc/BRIEF.md
# Sign-Magnitude Tree Multiplier

This block multiplies two 16-bit operands held in sign-magnitude form. The top bit of each operand is its sign, and the fifteen bits below it are an unsigned magnitude. The block is purely combinational. It has no clock, no reset and no internal state, so a change at its inputs shows up at its output after logic delay only.

The result sign is the exclusive-OR of the two operand signs. The 15x15 magnitude product is formed from a grid of AND-gate partial products. Layers of 3:2 carry-save adders work in parallel and reduce that grid to two rows. A block carry-lookahead adder then adds the two rows.

The 32-bit result places the sign in its most significant bit and a constant zero in the bit below it. The 30-bit magnitude product fills the low bits. A surrounding datapath uses the block as a single-cycle execution resource.

Top module: `sm_tree_mult`

## Requirements
- R1: Bit 15 of each operand is a sign flag and does not contribute to the magnitude, which is taken from bits 14:0 as an unsigned number.
- R2: Result bit 31 equals `mul_a_i[15] ^ mul_b_i[15]` for every operand pair.
- R3: Result bit 30 is 0 for every operand pair.
- R4: Result bits 29:0 equal the unsigned product `mul_a_i[14:0] * mul_b_i[14:0]`.
- R5: When either magnitude is zero, bits 29:0 are zero, and bit 31 still follows R2, so a signed zero may appear.
- R6: With both magnitudes at 0x7FFF, bits 29:0 equal 0x3FFF0001 for all four sign combinations.
- R7: The result depends only on the present inputs: a new operand pair is reflected at the output with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a_i | input | 16 | Multiplicand; bit 15 is the sign, bits 14:0 the magnitude |
| mul_b_i | input | 16 | Multiplier; bit 15 is the sign, bits 14:0 the magnitude |
| prod_o | output | 32 | Bit 31 is the sign, bit 30 is zero, bits 29:0 are the magnitude product |

## Verification
The bench goes after carries that cross group boundaries in the lookahead adder, using all-ones magnitudes and walking single bits. A wrong group carry or a dropped carry-save carry bit would corrupt the high product bits in those cases. It runs all four sign combinations against zero and full-scale magnitudes, which catches a design that lets a sign bit leak into the magnitude grid or that gates the sign with a zero product. A dense sweep of small magnitudes and a random sweep compare every field against arithmetic products. They would expose a misrouted row in the reduction layers, which shows up as an off-by-a-power-of-two error.

// File: rtl/sm_mult_pkg.sv
package sm_mult_pkg;

  // rows left after one 3:2 layer: each full group of three gives two rows
  function automatic int rows_after(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // rows present at the input of layer k when starting from n rows
  function automatic int rows_at(input int n, input int k);
    int r;
    r = n;
    for (int i = 0; i < k; i++) r = rows_after(r);
    return r;
  endfunction

  // number of layers needed to reach two rows
  function automatic int layer_count(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rows_after(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/sm_pp_grid.sv
module sm_pp_grid #(
  parameter int MAG_W = 15,
  localparam int PW = 2 * MAG_W
) (
  input  logic [MAG_W-1:0]    mag_a_i,
  input  logic [MAG_W-1:0]    mag_b_i,
  output logic [MAG_W*PW-1:0] rows_o
);

  // row j holds multiplicand AND multiplier bit j, shifted to column i+j
  for (genvar j = 0; j < MAG_W; j++) begin : g_row
    assign rows_o[j*PW +: PW] = ({PW{mag_b_i[j]}} & PW'(mag_a_i)) << j;

    always_comb begin
      if (!$isunknown({mag_a_i, mag_b_i[j]})) begin
        a_r4_pp_row: assert (rows_o[j*PW +: PW] ==
                             ((PW'(mag_a_i) * PW'(mag_b_i[j])) << j))
          else $error("R4 partial product row %0d wrong", j);
      end
    end
  end

endmodule

// File: rtl/sm_csa_layer.sv
module sm_csa_layer #(
  parameter int W    = 30,
  parameter int N_IN = 15,
  localparam int N_GRP  = N_IN / 3,
  localparam int N_LEFT = N_IN % 3,
  localparam int N_OUT  = 2 * N_GRP + N_LEFT
) (
  input  logic [N_IN*W-1:0]  rows_i,
  output logic [N_OUT*W-1:0] rows_o
);

  // each group of three rows becomes a sum row and a shifted carry row
  for (genvar g = 0; g < N_GRP; g++) begin : g_fa
    logic [W-1:0] x, y, z;
    assign x = rows_i[(3*g)*W   +: W];
    assign y = rows_i[(3*g+1)*W +: W];
    assign z = rows_i[(3*g+2)*W +: W];
    assign rows_o[(2*g)*W   +: W] = x ^ y ^ z;
    assign rows_o[(2*g+1)*W +: W] = ((x & y) | (x & z) | (y & z)) << 1;
  end

  // rows that do not fill a group pass to the next layer unchanged
  for (genvar r = 0; r < N_LEFT; r++) begin : g_pass
    assign rows_o[(2*N_GRP+r)*W +: W] = rows_i[(3*N_GRP+r)*W +: W];
  end

  logic [W-1:0] tot_in, tot_out;
  always_comb begin
    tot_in  = '0;
    tot_out = '0;
    for (int k = 0; k < N_IN; k++)  tot_in  = tot_in  + rows_i[k*W +: W];
    for (int k = 0; k < N_OUT; k++) tot_out = tot_out + rows_o[k*W +: W];
    if (!$isunknown(rows_i)) begin
      a_r4_csa_keeps_sum: assert (tot_in == tot_out)
        else $error("R4 carry-save layer changed the row total");
    end
  end

endmodule

// File: rtl/sm_cla_adder.sv
module sm_cla_adder #(
  parameter int W  = 30,
  parameter int GW = 4,
  localparam int NG = (W + GW - 1) / GW,
  localparam int EW = NG * GW
) (
  input  logic [W-1:0] add_a_i,
  input  logic [W-1:0] add_b_i,
  output logic [W-1:0] sum_o
);

  logic [EW-1:0] gen, prop;
  logic [NG-1:0] grp_g, grp_p, grp_c;
  logic [W-1:0]  bit_c;

  // bit generate and propagate terms
  always_comb begin
    gen  = EW'(add_a_i) & EW'(add_b_i);
    prop = EW'(add_a_i) ^ EW'(add_b_i);
  end

  // group generate and propagate, then lookahead across groups
  always_comb begin
    logic acc;
    for (int k = 0; k < NG; k++) begin
      grp_p[k] = &prop[k*GW +: GW];
      acc = 1'b0;
      for (int i = 0; i < GW; i++)
        acc = gen[k*GW+i] | (prop[k*GW+i] & acc);
      grp_g[k] = acc;
    end
    grp_c[0] = 1'b0;
    for (int k = 1; k < NG; k++)
      grp_c[k] = grp_g[k-1] | (grp_p[k-1] & grp_c[k-1]);
  end

  // carries inside each group start from the lookahead group carry
  always_comb begin
    logic c;
    bit_c = '0;
    for (int k = 0; k < NG; k++) begin
      c = grp_c[k];
      for (int i = 0; i < GW; i++) begin
        if (k*GW + i < W) bit_c[k*GW+i] = c;
        c = gen[k*GW+i] | (prop[k*GW+i] & c);
      end
    end
  end

  assign sum_o = prop[W-1:0] ^ bit_c;

  always_comb begin
    if (!$isunknown({add_a_i, add_b_i})) begin
      a_r4_cla_sum: assert (sum_o == W'(add_a_i + add_b_i))
        else $error("R4 lookahead adder sum wrong");
    end
  end

endmodule

// File: rtl/sm_tree_mult.sv
module sm_tree_mult
  import sm_mult_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int MAG_W = WIDTH - 1,
  localparam int PW    = 2 * MAG_W,
  localparam int NL    = layer_count(MAG_W)
) (
  input  logic [WIDTH-1:0]   mul_a_i,
  input  logic [WIDTH-1:0]   mul_b_i,
  output logic [2*WIDTH-1:0] prod_o
);

  logic [MAG_W-1:0]    mag_a, mag_b;
  logic                sgn;
  logic [MAG_W*PW-1:0] grid;
  logic [PW-1:0]       mag_prod;

  // R1: split sign from magnitude
  assign mag_a = mul_a_i[MAG_W-1:0];
  assign mag_b = mul_b_i[MAG_W-1:0];
  assign sgn   = mul_a_i[WIDTH-1] ^ mul_b_i[WIDTH-1];

  sm_pp_grid #(.MAG_W(MAG_W)) u_grid (
    .mag_a_i (mag_a),
    .mag_b_i (mag_b),
    .rows_o  (grid)
  );

  for (genvar L = 0; L < NL; L++) begin : g_lay
    localparam int NIN  = rows_at(MAG_W, L);
    localparam int NOUT = rows_at(MAG_W, L + 1);
    logic [NIN*PW-1:0]  vin;
    logic [NOUT*PW-1:0] vout;
    if (L == 0) begin : g_first
      assign vin = grid;
    end else begin : g_next
      assign vin = g_lay[L-1].vout;
    end
    sm_csa_layer #(.W(PW), .N_IN(NIN)) u_layer (
      .rows_i (vin),
      .rows_o (vout)
    );
  end

  sm_cla_adder #(.W(PW), .GW(4)) u_final (
    .add_a_i (g_lay[NL-1].vout[0 +: PW]),
    .add_b_i (g_lay[NL-1].vout[PW +: PW]),
    .sum_o   (mag_prod)
  );

  // R2, R3, R4: sign on top, a zero bit, magnitude below
  assign prod_o = {sgn, 1'b0, mag_prod};

  always_comb begin
    if (!$isunknown({mul_a_i, mul_b_i})) begin
      a_r4_magnitude: assert (prod_o[PW-1:0] == PW'(PW'(mag_a) * PW'(mag_b)))
        else $error("R4 magnitude product wrong");
      a_r5_zero_mag: assert (!((mag_a == '0) || (mag_b == '0)) ||
                             (prod_o[PW-1:0] == '0))
        else $error("R5 zero magnitude gave nonzero product");
    end
  end

endmodule

// File: tb/sm_tree_mult_tb_top.sv
module sm_tree_mult_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  WIDTH      = 16;
  localparam int  MAX_CYC    = 150000;

  logic              clk = 1'b0;
  logic [WIDTH-1:0]  a, b;
  logic [2*WIDTH-1:0] p;
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  sm_tree_mult #(.WIDTH(WIDTH)) dut_i (
    .mul_a_i (a),
    .mul_b_i (b),
    .prod_o  (p)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input logic [15:0] oa,
                       input logic [15:0] ob);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, oa, ob, act, exp);
    end
  endtask

  function automatic logic [29:0] mag_ref(input logic [15:0] x, input logic [15:0] y);
    longint ma, mb;
    ma = longint'(x & 16'h7FFF);
    mb = longint'(y & 16'h7FFF);
    return 30'(ma * mb);
  endfunction

  // drive one pair, sample on the falling edge, check every field
  task automatic run_vec(input logic [15:0] va, input logic [15:0] vb);
    @(posedge clk);
    a = va;
    b = vb;
    @(negedge clk);
    check("R2 sign", {31'd0, p[31]}, {31'd0, va[15] ^ vb[15]}, va, vb);
    check("R3 zero bit", {31'd0, p[30]}, 32'd0, va, vb);
    check("R1 R4 magnitude", {2'b00, p[29:0]}, {2'b00, mag_ref(va, vb)}, va, vb);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > MAX_CYC) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d cycles", cyc, MAX_CYC);
        finish_run();
      end
    end
  end

  initial begin
    a = '0;
    b = '0;
    @(negedge clk);
    // initial state: zero operands give an all-zero word
    check("R5 zero start", p, 32'h0000_0000, a, b);

    // R5 and R6: zero and full-scale magnitudes under every sign pair
    for (int s = 0; s < 4; s++) begin
      logic [15:0] sa, sb;
      sa = {s[1], 15'd0};
      sb = {s[0], 15'd0};
      run_vec(sa | 16'h7FFF, sb | 16'h7FFF);
      check("R6 full scale", p, {s[1] ^ s[0], 1'b0, 30'h3FFF0001}, a, b);
      run_vec(sa, sb | 16'h1234);
      check("R5 zero magnitude", p, {s[1] ^ s[0], 31'd0}, a, b);
      run_vec(sa | 16'h7FFF, sb);
      check("R5 zero magnitude", p, {s[1] ^ s[0], 31'd0}, a, b);
    end

    // R1: sign bit must not enter the magnitude
    run_vec(16'h8001, 16'h8001);
    check("R1 sign excluded", p, 32'h0000_0001, a, b);

    // walking ones against full scale and each other, all sign pairs
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 15; i++) begin
        run_vec({s[1], 15'(1 << i)}, {s[0], 15'h7FFF});
        for (int j = 0; j < 15; j += 3)
          run_vec({s[1], 15'(1 << i)}, {s[0], 15'(1 << j)});
      end
    end

    // dense sweep of small magnitudes
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        run_vec(16'(x) | ((x & 1) != 0 ? 16'h8000 : 16'h0), 16'(y) | ((y & 2) != 0 ? 16'h8000 : 16'h0));

    // random sweep
    for (int k = 0; k < 20000; k++)
      run_vec(16'($urandom), 16'($urandom));

    // R7: output follows a new pair with no clock edge in between
    @(negedge clk);
    a = 16'h0003;
    b = 16'h8005;
    #1;
    check("R7 no clock", p, 32'h8000_000F, a, b);
    a = 16'h7FFF;
    b = 16'h0002;
    #1;
    check("R7 no clock", p, 32'h0000_FFFE, a, b);

    finish_run();
  end

endmodule